// File: doc/BRIEF.md
# USB Packet Transmit Serializer

This block turns a packet handed over by a protocol engine as 16-bit words into the serial line-state stream of a USB transmitter. Words are taken through a valid/ready handshake and split into bytes, low byte first. An odd-length packet is closed with a word whose high-byte flag is low. The block can append a CRC16 over everything after the first (PID) byte. It frames the packet with a sync field and an end-of-packet marker, bit-stuffs the stream, and NRZI-encodes it. One line symbol is produced per strobe of a bit-enable input.

The CRC-enable input has two uses. Its value when the first word of a packet is taken decides whether a CRC is appended. If that value was high, pulling the input low while payload or CRC bits are still being sent aborts the packet. The block then sends an unstuffed run of ones, which a receiver flags as a stuffing error, followed by an end-of-packet marker.

Top module: `usb_tx_datapath`

## Requirements
- R1: After reset and between packets, `line_state` is J, `line_oe` is low and `tx_ready` is high. The line codes are {D+,D-}: J = 2'b10, K = 2'b01, SE0 = 2'b00.
- R2: A packet on the line starts with a sync field of SYNC_BITS-1 zero bits followed by a one bit. Payload bytes follow least-significant bit first, and the low byte of a word goes before its high byte. The packet ends with EOP_SE0 SE0 symbols and then one J. `line_oe` is high from the first sync symbol through that J.
- R3: A word accepted with `tx_hi_ok` low contributes only its low byte and ends the payload.
- R4: A cycle with `tx_ready` high and `tx_valid` low during a packet's payload marks the end of the payload.
- R5: If `crc_en` is high on the cycle the first word is accepted, a CRC16 follows the payload. The CRC uses polynomial x^16+x^15+x^2+1, is seeded with all ones, covers every payload byte except the first, and is sent inverted, least-significant bit first.
- R6: After six consecutive one bits, a zero bit is inserted. The count runs across sync, payload and CRC, and an insertion still due at the end of the CRC or payload is sent before the EOP.
- R7: Each encoded zero bit toggles the line between J and K, each one bit repeats the previous level, and the first sync bit is encoded against a J level.
- R8: `tx_ready` is low during sync, CRC, abort and EOP, and while an accepted word still holds an unsent byte.
- R9: In a packet that carries a CRC, a low `crc_en` seen on a strobe that sends a payload or CRC bit ends that bit's packet body. ABORT_ONES unstuffed one bits (line level unchanged) follow, then the EOP of R2.
- R10: In a packet without a CRC, changes of `crc_en` after the first word have no effect on the line stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | Bit-enable strobe; one line symbol per strobe |
| tx_valid | input | 1 | Upstream holds high for the whole packet |
| tx_word | input | 16 | Payload word, bits [7:0] sent first |
| tx_hi_ok | input | 1 | High byte of `tx_word` is valid |
| crc_en | input | 1 | CRC select at packet start; abort request when dropped |
| tx_ready | output | 1 | Word accepted on a cycle with `tx_valid` high |
| line_state | output | 2 | Line symbol {D+,D-} |
| line_oe | output | 1 | High while a packet is driven |

## Verification
Two pairs of functions can land on the same strobe. The first pair is a pending stuff bit and the switch from the last CRC or payload bit to the EOP. All-ones payloads and random packets with many 0xFF bytes provoke it, and the bench's own stuffing model must place the inserted zero before the first SE0. The second pair is an abort and the stuffing counter. Dropping `crc_en` in the middle of 0xFF-heavy payloads makes the forced run start while the counter is part-way up. The result is judged by a run of at least eight identical symbols ending right at the SE0 pair, behind a prefix that matches the normal stream.

// File: rtl/usbtx_pkg.sv
package usbtx_pkg;
   typedef enum logic [1:0] {SK_IDLE, SK_BIT, SK_SE0, SK_J} sym_kind_t;
   typedef enum logic [2:0] {FS_IDLE, FS_SYNC, FS_DATA, FS_CRC, FS_ABORT, FS_EOP} fstate_t;

   localparam logic [1:0] J_CODE   = 2'b10;
   localparam logic [1:0] K_CODE   = 2'b01;
   localparam logic [1:0] SE0_CODE = 2'b00;
   localparam int          CRC_W    = 16;
   localparam logic [CRC_W-1:0] CRC_POLY_REFL = 16'hA001;

   function automatic logic [CRC_W-1:0] crc16_step(input logic [CRC_W-1:0] c, input logic b);
      logic [CRC_W-1:0] n;
      n = c >> 1;
      if (c[0] ^ b) n = n ^ CRC_POLY_REFL;
      return n;
   endfunction
endpackage

// File: rtl/usbtx_framer.sv
module usbtx_framer
   import usbtx_pkg::*;
#(
   parameter int WORD_W     = 16,
   parameter int SYNC_BITS  = 8,
   parameter int ABORT_ONES = 8,
   parameter int EOP_SE0    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_stb,
   input  logic              stall,
   input  logic              tx_valid,
   input  logic [WORD_W-1:0] tx_word,
   input  logic              tx_hi_ok,
   input  logic              crc_en,
   output logic              tx_ready,
   output sym_kind_t         kind,
   output logic              bit_o,
   output logic              nostuff
);
   localparam int BYTE_W = 8;
   localparam int BYTES  = WORD_W / BYTE_W;
   localparam int HN_W   = $clog2(BYTES + 1);
   localparam int BIT_W  = $clog2(BYTE_W);
   localparam int CNT_W  = $clog2(SYNC_BITS + ABORT_ONES + CRC_W + EOP_SE0 + 1);

   fstate_t            st;
   logic [CNT_W-1:0]   cnt;
   logic [WORD_W-1:0]  hold;
   logic [HN_W-1:0]    hold_n;
   logic               last, use_crc, is_pid;
   logic [BYTE_W-1:0]  sh;
   logic [BIT_W-1:0]   nbit;
   logic [CRC_W-1:0]   crc;

   wire advance   = bit_stb & ~stall;
   wire abort_req = use_crc & ~crc_en;

   assign tx_ready = (st == FS_IDLE) | ((st == FS_DATA) & (hold_n == '0) & ~last);

   always_comb begin
      kind    = SK_BIT;
      bit_o   = 1'b1;
      nostuff = 1'b0;
      unique case (st)
         FS_IDLE:  kind  = SK_IDLE;
         FS_SYNC:  bit_o = (cnt == CNT_W'(SYNC_BITS - 1));
         FS_DATA:  bit_o = sh[0];
         FS_CRC:   bit_o = ~crc[0];
         FS_ABORT: nostuff = 1'b1;
         FS_EOP:   kind  = (cnt < CNT_W'(EOP_SE0)) ? SK_SE0 : SK_J;
         default:  kind  = SK_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= FS_IDLE;  cnt <= '0;  hold <= '0;  hold_n <= '0;
         last <= 1'b0;   use_crc <= 1'b0;  is_pid <= 1'b0;
         sh <= '0;       nbit <= '0;  crc <= '1;
      end else begin
         // word intake (only when the holding register is empty)
         if (tx_valid && tx_ready) begin
            hold   <= tx_word;
            hold_n <= tx_hi_ok ? HN_W'(BYTES) : HN_W'(1);
            last   <= ~tx_hi_ok;
            if (st == FS_IDLE) begin
               st      <= FS_SYNC;
               cnt     <= '0;
               use_crc <= crc_en;
            end
         end else if (tx_ready && st == FS_DATA) begin
            last <= 1'b1;
         end
         // symbol sequencing, one step per unstalled strobe
         if (advance) begin
            unique case (st)
               FS_SYNC: begin
                  if (cnt == CNT_W'(SYNC_BITS - 1)) begin
                     sh     <= hold[BYTE_W-1:0];
                     hold   <= hold >> BYTE_W;
                     hold_n <= hold_n - 1'b1;
                     nbit   <= '0;
                     is_pid <= 1'b1;
                     crc    <= '1;
                     st     <= FS_DATA;
                  end else cnt <= cnt + 1'b1;
               end
               FS_DATA: begin
                  if (abort_req) begin
                     st <= FS_ABORT;  cnt <= '0;
                  end else begin
                     if (!is_pid) crc <= crc16_step(crc, sh[0]);
                     sh   <= sh >> 1;
                     nbit <= nbit + 1'b1;
                     if (nbit == BIT_W'(BYTE_W - 1)) begin
                        if (hold_n != '0) begin
                           sh     <= hold[BYTE_W-1:0];
                           hold   <= hold >> BYTE_W;
                           hold_n <= hold_n - 1'b1;
                           is_pid <= 1'b0;
                        end else begin
                           st  <= use_crc ? FS_CRC : FS_EOP;
                           cnt <= '0;
                        end
                     end
                  end
               end
               FS_CRC: begin
                  if (abort_req) begin
                     st <= FS_ABORT;  cnt <= '0;
                  end else begin
                     crc <= crc >> 1;
                     cnt <= cnt + 1'b1;
                     if (cnt == CNT_W'(CRC_W - 1)) begin
                        st <= FS_EOP;  cnt <= '0;
                     end
                  end
               end
               FS_ABORT: begin
                  if (cnt == CNT_W'(ABORT_ONES - 1)) begin
                     st <= FS_EOP;  cnt <= '0;
                  end else cnt <= cnt + 1'b1;
               end
               FS_EOP: begin
                  if (cnt == CNT_W'(EOP_SE0)) st <= FS_IDLE;
                  else cnt <= cnt + 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   // R8: a byte boundary never finds the holding register empty mid-packet
   assert_no_underrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && st == FS_DATA && nbit == BIT_W'(BYTE_W - 1) && !abort_req)
         |-> (hold_n != '0 || last))
      else $error("payload underrun at byte boundary");

   // R10: the abort path is reachable only from a packet that carries a CRC
   assert_abort_crc_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == FS_ABORT) |-> use_crc)
      else $error("abort entered in packet without CRC");
endmodule

// File: rtl/usbtx_line_enc.sv
module usbtx_line_enc
   import usbtx_pkg::*;
#(
   parameter int STUFF_RUN = 6
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      bit_stb,
   input  sym_kind_t kind,
   input  logic      bit_i,
   input  logic      nostuff,
   output logic      stall,
   output logic [1:0] line_state,
   output logic      line_oe
);
   localparam int RW = $clog2(STUFF_RUN + 1);

   logic [RW-1:0] ones;
   logic          lvl;   // 1 = J

   assign stall = (ones == RW'(STUFF_RUN)) && (kind != SK_IDLE) && !nostuff;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ones <= '0;  lvl <= 1'b1;  line_state <= J_CODE;  line_oe <= 1'b0;
      end else if (bit_stb) begin
         if (kind == SK_IDLE) begin
            ones <= '0;  lvl <= 1'b1;  line_state <= J_CODE;  line_oe <= 1'b0;
         end else begin
            line_oe <= 1'b1;
            if (stall || (kind == SK_BIT && !bit_i)) begin
               lvl        <= ~lvl;
               line_state <= lvl ? K_CODE : J_CODE;
               ones       <= '0;
            end else if (kind == SK_BIT) begin
               line_state <= lvl ? J_CODE : K_CODE;
               ones       <= nostuff ? '0 : ones + 1'b1;
            end else if (kind == SK_SE0) begin
               line_state <= SE0_CODE;
               ones       <= '0;
            end else begin
               line_state <= J_CODE;
               lvl        <= 1'b1;
               ones       <= '0;
            end
         end
      end
   end

   // R6: the run counter never passes the stuffing limit
   assert_stuff_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ones <= RW'(STUFF_RUN))
      else $error("stuffing run exceeded");

   // R2: the driven packet always closes on a J symbol
   assert_eop_tail_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(line_oe) |-> ($past(line_state) == J_CODE))
      else $error("packet did not end on J");

   // R7: an unstuffed one bit keeps the line level
   assert_nrzi_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && kind == SK_BIT && !stall && bit_i) |=> (line_state == $past(line_state)))
      else $error("one bit changed line level");
endmodule

// File: rtl/usb_tx_datapath.sv
module usb_tx_datapath
   import usbtx_pkg::*;
#(
   parameter int WORD_W     = 16,
   parameter int SYNC_BITS  = 8,
   parameter int STUFF_RUN  = 6,
   parameter int ABORT_ONES = 8,
   parameter int EOP_SE0    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_stb,
   input  logic              tx_valid,
   input  logic [WORD_W-1:0] tx_word,
   input  logic              tx_hi_ok,
   input  logic              crc_en,
   output logic              tx_ready,
   output logic [1:0]        line_state,
   output logic              line_oe
);
   generate
      if (WORD_W % 8 != 0 || WORD_W < 16) begin : g_bad_word
         $error("WORD_W must be a multiple of 8 and at least 16");
      end
      if (ABORT_ONES <= STUFF_RUN) begin : g_bad_abort
         $error("ABORT_ONES must exceed STUFF_RUN to form a stuffing error");
      end
      if (SYNC_BITS < 2 || EOP_SE0 < 1) begin : g_bad_frame
         $error("SYNC_BITS >= 2 and EOP_SE0 >= 1 required");
      end
   endgenerate

   sym_kind_t kind;
   logic      bit_s, nostuff, stall;

   usbtx_framer #(
      .WORD_W(WORD_W), .SYNC_BITS(SYNC_BITS),
      .ABORT_ONES(ABORT_ONES), .EOP_SE0(EOP_SE0)
   ) u_framer (
      .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .stall(stall),
      .tx_valid(tx_valid), .tx_word(tx_word), .tx_hi_ok(tx_hi_ok), .crc_en(crc_en),
      .tx_ready(tx_ready), .kind(kind), .bit_o(bit_s), .nostuff(nostuff)
   );

   usbtx_line_enc #(.STUFF_RUN(STUFF_RUN)) u_line (
      .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .kind(kind), .bit_i(bit_s),
      .nostuff(nostuff), .stall(stall), .line_state(line_state), .line_oe(line_oe)
   );
endmodule

// File: tb/tb_usb_tx_datapath.sv
module tb_usb_tx_datapath;
   localparam int CLK_PERIOD = 10;
   localparam int SYNC_BITS  = 8;
   localparam int ABORT_ONES = 8;
   localparam int WD_LIMIT   = 150000;
   localparam logic [1:0] LJ = 2'b10, LK = 2'b01, LSE0 = 2'b00;

   logic clk = 1'b0, rst_n = 1'b0, bit_stb = 1'b0;
   logic tx_valid = 1'b0, tx_hi_ok = 1'b0, crc_en = 1'b0;
   logic [15:0] tx_word = '0;
   logic tx_ready, line_oe;
   logic [1:0] line_state;

   usb_tx_datapath dut (
      .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .tx_valid(tx_valid),
      .tx_word(tx_word), .tx_hi_ok(tx_hi_ok), .crc_en(crc_en),
      .tx_ready(tx_ready), .line_state(line_state), .line_oe(line_oe)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0, n_fail = 0, cyc = 0, ready_bad = 0;
   int cap_n = 0, exp_n = 0;
   logic [1:0] cap [0:1023];
   logic [1:0] expd[0:1023];
   logic [7:0] pkt [0:63];
   bit quit = 1'b0;

   task automatic chk(input bit ok, input string msg);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s", msg);
      end
   endtask

   // capture, ready monitor and strobe generation share one negedge process
   always @(negedge clk) begin
      if (bit_stb && line_oe && cap_n < 1024) begin
         cap[cap_n] = line_state;
         cap_n++;
      end
      if (line_oe && tx_ready && (cap_n < SYNC_BITS || line_state == LSE0)) ready_bad++;
      bit_stb = rst_n && ($urandom_range(0, 2) != 0);
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > WD_LIMIT) begin
         n_chk++; n_fail++;
         $display("FAIL R2 watchdog actual=hung expected=packet_done");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   // expected line stream from the requirements (R2, R5, R6, R7)
   task automatic build_exp(input int n, input bit crc_on);
      bit raw [0:1023];
      int rn = 0, ones = 0;
      bit lvl = 1'b1;
      logic [15:0] c;
      for (int i = 0; i < SYNC_BITS; i++) begin raw[rn] = (i == SYNC_BITS-1); rn++; end
      for (int b = 0; b < n; b++)
         for (int k = 0; k < 8; k++) begin raw[rn] = pkt[b][k]; rn++; end
      if (crc_on) begin
         c = 16'hFFFF;
         for (int b = 1; b < n; b++)
            for (int k = 0; k < 8; k++) begin
               bit fb;
               fb = c[0] ^ pkt[b][k];
               c = c >> 1;
               if (fb) c = c ^ 16'hA001;
            end
         c = ~c;
         for (int k = 0; k < 16; k++) begin raw[rn] = c[k]; rn++; end
      end
      exp_n = 0;
      for (int i = 0; i < rn; i++) begin
         if (!raw[i]) lvl = ~lvl;
         expd[exp_n] = lvl ? LJ : LK; exp_n++;
         ones = raw[i] ? ones + 1 : 0;
         if (ones == 6) begin
            lvl = ~lvl;
            expd[exp_n] = lvl ? LJ : LK; exp_n++;
            ones = 0;
         end
      end
      expd[exp_n] = LSE0; exp_n++;
      expd[exp_n] = LSE0; exp_n++;
      expd[exp_n] = LJ;   exp_n++;
   endtask

   task automatic send_pkt(input int n);
      for (int w = 0; w < (n + 1) / 2; w++) begin
         if (quit) break;
         @(negedge clk);
         tx_valid = 1'b1;
         tx_word  = {(2*w+1 < n) ? pkt[2*w+1] : 8'h00, pkt[2*w]};
         tx_hi_ok = (2*w+1 < n);
         while (!tx_ready && !quit) @(negedge clk);
         if (quit) break;
         @(posedge clk);
      end
      @(negedge clk);
      tx_valid = 1'b0;
   endtask

   task automatic wait_done();
      do @(negedge clk); while (!(cap_n > 0 && !line_oe));
   endtask

   task automatic cmp_stream(input string tag);
      int mis = -1;
      for (int i = 0; i < exp_n; i++)
         if (mis < 0 && (i >= cap_n || cap[i] !== expd[i])) mis = i;
      if (mis < 0 && cap_n != exp_n) mis = exp_n;
      chk(mis < 0, $sformatf("%s stream: len act=%0d exp=%0d first_diff=%0d act=%b exp=%b",
          tag, cap_n, exp_n, mis, (mis >= 0 && mis < cap_n) ? cap[mis] : 2'bxx,
          (mis >= 0 && mis < exp_n) ? expd[mis] : 2'bxx));
   endtask

   task automatic run_pkt(input int n, input bit crc_on, input string tag);
      @(negedge clk);
      build_exp(n, crc_on);
      cap_n = 0; quit = 1'b0; crc_en = crc_on;
      send_pkt(n);
      wait_done();
      cmp_stream(tag);
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(line_state == LJ, $sformatf("R1 idle line act=%b exp=%b", line_state, LJ));
      chk(line_oe == 1'b0 && tx_ready == 1'b1,
          $sformatf("R1 idle oe/ready act=%b%b exp=01", line_oe, tx_ready));

      // directed corner cases
      pkt[0] = 8'hD2;
      run_pkt(1, 1'b0, "R3 R2 single PID byte no CRC");
      run_pkt(1, 1'b1, "R5 PID-only packet empty CRC");
      pkt[0] = 8'hC3; pkt[1] = 8'h5A;
      run_pkt(2, 1'b1, "R4 R2 even two-byte CRC");
      pkt[2] = 8'h81;
      run_pkt(3, 1'b1, "R3 odd three-byte CRC");
      for (int i = 0; i < 8; i++) pkt[i] = 8'hFF;
      run_pkt(8, 1'b1, "R6 all-ones payload");
      run_pkt(7, 1'b0, "R6 R7 all-ones no CRC stuff before EOP");
      chk(line_state == LJ && tx_ready, $sformatf("R1 idle after packet act=%b%b exp=%b1",
          line_state, tx_ready, LJ));

      // R10: crc_en toggling in a no-CRC packet
      for (int i = 0; i < 12; i++) pkt[i] = 8'($urandom);
      @(negedge clk);
      build_exp(12, 1'b0); cap_n = 0; quit = 1'b0; crc_en = 1'b0;
      fork
         send_pkt(12);
         begin
            wait (cap_n >= 24); @(negedge clk); crc_en = 1'b1;
            repeat (10) @(negedge clk); crc_en = 1'b0;
         end
      join
      wait_done();
      cmp_stream("R10 crc_en changes ignored");

      // R9: abort a CRC packet mid-payload
      for (int i = 0; i < 12; i++) pkt[i] = ($urandom_range(0, 1) == 0) ? 8'hFF : 8'($urandom);
      @(negedge clk);
      build_exp(12, 1'b1); cap_n = 0; quit = 1'b0; crc_en = 1'b1;
      fork
         send_pkt(12);
         begin
            wait (cap_n >= 30); @(negedge clk); crc_en = 1'b0; quit = 1'b1;
         end
      join
      wait_done();
      begin
         int se = -1, run = 0, pre_ok = 1;
         for (int i = 0; i < cap_n; i++) if (se < 0 && cap[i] == LSE0) se = i;
         if (se > 0) begin
            run = 1;
            for (int i = se - 2; i >= 0 && cap[i] == cap[se-1]; i--) run++;
         end
         for (int i = 0; i < 24; i++) if (cap[i] !== expd[i]) pre_ok = 0;
         chk(pre_ok == 1, $sformatf("R9 abort prefix act=%0d exp=1", pre_ok));
         chk(run >= ABORT_ONES, $sformatf("R9 abort run before SE0 act=%0d exp>=%0d", run, ABORT_ONES));
         chk(se >= 0 && cap_n == se + 3 && cap[se+1] == LSE0 && cap[se+2] == LJ,
             $sformatf("R9 abort EOP tail act=se%0d/len%0d exp=len=se+3", se, cap_n));
         chk(cap_n < exp_n, $sformatf("R9 abort shortens packet act=%0d exp<%0d", cap_n, exp_n));
      end
      crc_en = 1'b0;

      // constrained random packets
      for (int p = 0; p < 24; p++) begin
         int n;
         bit c;
         n = $urandom_range(1, 20);
         c = $urandom_range(0, 1);
         for (int i = 0; i < n; i++) pkt[i] = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom);
         run_pkt(n, c, $sformatf("R2 R4 R5 R6 R7 random pkt%0d n=%0d crc=%0d", p, n, c));
      end

      chk(ready_bad == 0, $sformatf("R8 ready during sync/EOP act=%0d exp=0", ready_bad));
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule